// File: doc/BRIEF.md
# UART DMA Request Generator

This block drives the two level-sensitive DMA request lines of a UART that has receive and transmit FIFOs. From the receive and transmit occupancy (a byte count in FIFO operation, a single holding-register flag otherwise), the receive trigger-level select, the character-timeout pulse, the transmit write strobe and two FIFO clear pulses, it decides when a DMA controller should move data in or out. A DMA controller services the receive request by reading bytes and the transmit request by writing bytes.

There are two request policies. The immediate policy (mode 0) follows occupancy: receive asks while any byte is waiting, and transmit asks while the transmit side is empty. The hysteresis policy (mode 1) only applies with the FIFOs enabled. It raises the receive request at the trigger level or on a timeout and keeps it up until the FIFO drains. It raises the transmit request when the FIFO empties and keeps it up until the FIFO is completely full. Both outputs are registered and each is gated by its own enable.

Top module: `uart_dma_req`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both request outputs are low.
- R2: In mode 0 with FIFOs enabled, the receive request in cycle n+1 equals the receive enable AND (receive byte count in cycle n is nonzero).
- R3: In mode 0, the transmit request in cycle n+1 equals the transmit enable AND (transmit side empty in cycle n) AND NOT (transmit write strobe in cycle n).
- R4: In mode 1, the receive latch sets when the receive count is at or above the trigger level, or when the timeout pulse is high and the count is nonzero. Trigger select codes 0, 1, 2 and 3 give levels of 1, 4, 8 and 14 bytes.
- R5: In mode 1, once set, the receive latch stays set while the receive count is nonzero, and clears in the cycle the count is zero.
- R6: In mode 1, the transmit latch sets when the transmit count is zero. It stays set until the count reaches 16 (full), and then stays clear until the count is zero again.
- R7: A low enable forces the matching request low one cycle later. Both latches keep tracking while their requests are masked.
- R8: A receive clear pulse clears the receive latch. A transmit clear pulse sets the transmit latch, because the FIFO is then empty. Either clear takes priority over the count.
- R9: With FIFOs disabled, the mode bit is ignored. The receive side counts as holding data when the receive-full flag is 1, and the transmit side counts as empty when the transmit-full flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_on | input | 1 | FIFOs enabled (byte counts used) |
| hyst_mode | input | 1 | 0: immediate policy, 1: hysteresis policy |
| rx_dma_en | input | 1 | Receive request enable |
| tx_dma_en | input | 1 | Transmit request enable |
| trig_sel | input | 2 | Receive trigger level select |
| rx_level | input | 5 | Receive FIFO byte count |
| tx_level | input | 5 | Transmit FIFO byte count |
| rx_hold_full | input | 1 | Receive holding register has data (FIFOs off) |
| tx_hold_full | input | 1 | Transmit holding register has data (FIFOs off) |
| rx_timeout | input | 1 | Receive character timeout pulse |
| tx_wr | input | 1 | Write strobe into the transmit path |
| rx_flush | input | 1 | Receive FIFO clear pulse |
| tx_flush | input | 1 | Transmit FIFO clear pulse |
| rx_req | output | 1 | Receive DMA request |
| tx_req | output | 1 | Transmit DMA request |

## Verification
The bench ramps each FIFO count from empty to full and back down, once for every trigger code. A design that compared the count against the wrong threshold would raise the receive request one byte early or late. A design without hysteresis would drop the transmit request as soon as the first byte arrived instead of at full. Timeouts are given with an empty FIFO and with one byte, so a design that let a timeout set the latch on an empty FIFO would show a spurious request. Clear pulses are given while the FIFO stays full, to confirm that a clear wins over the count. Long random runs toggle the enables while the latches change state underneath them.

// File: rtl/uart_dma_req.sv
module uart_dma_req #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_on,
  input  logic          hyst_mode,
  input  logic          rx_dma_en,
  input  logic          tx_dma_en,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] rx_level,
  input  logic [CW-1:0] tx_level,
  input  logic          rx_hold_full,
  input  logic          tx_hold_full,
  input  logic          rx_timeout,
  input  logic          tx_wr,
  input  logic          rx_flush,
  input  logic          tx_flush,
  output logic          rx_req,
  output logic          tx_req
);

  localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] LVL_Q    = CW'(DEPTH / 4);
  localparam logic [CW-1:0] LVL_H    = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LVL_NF   = CW'(DEPTH - 2);

  logic          rx_hold_q, tx_hold_q;
  logic          rx_hold_d, tx_hold_d;
  logic [CW-1:0] trig_lvl;

  always_comb begin
    case (trig_sel)
      2'd0:    trig_lvl = CW'(1);
      2'd1:    trig_lvl = LVL_Q;
      2'd2:    trig_lvl = LVL_H;
      default: trig_lvl = LVL_NF;
    endcase
  end

  wire use_hyst  = fifo_on & hyst_mode;
  wire rx_empty  = (rx_level == '0);
  wire rx_avail  = fifo_on ? !rx_empty : rx_hold_full;
  wire tx_vacant = fifo_on ? (tx_level == '0) : !tx_hold_full;

  always_comb begin
    if (rx_flush || rx_empty)                     rx_hold_d = 1'b0;
    else if (rx_level >= trig_lvl || rx_timeout)  rx_hold_d = 1'b1;
    else                                          rx_hold_d = rx_hold_q;
  end

  always_comb begin
    if (tx_flush)                   tx_hold_d = 1'b1;
    else if (tx_level >= LVL_FULL)  tx_hold_d = 1'b0;
    else if (tx_level == '0)        tx_hold_d = 1'b1;
    else                            tx_hold_d = tx_hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold_q <= 1'b0;
      tx_hold_q <= 1'b0;
      rx_req    <= 1'b0;
      tx_req    <= 1'b0;
    end else begin
      rx_hold_q <= rx_hold_d;
      tx_hold_q <= tx_hold_d;
      rx_req    <= rx_dma_en & (use_hyst ? rx_hold_d : rx_avail);
      tx_req    <= tx_dma_en & (use_hyst ? tx_hold_d : (tx_vacant & ~tx_wr));
    end
  end

endmodule

module uart_dma_req_chk #(
  parameter int CW = 5,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_on,
  input logic          hyst_mode,
  input logic          rx_dma_en,
  input logic          tx_dma_en,
  input logic [CW-1:0] rx_level,
  input logic [CW-1:0] tx_level,
  input logic          tx_wr,
  input logic          rx_flush,
  input logic          rx_req,
  input logic          tx_req
);
  // R7
  rx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dma_en |=> !rx_req);
  // R7
  tx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_dma_en |=> !tx_req);
  // R2
  rx_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_on && !hyst_mode && rx_dma_en && rx_level != '0) |=> rx_req);
  // R3
  tx_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(fifo_on && hyst_mode) && tx_wr) |=> !tx_req);
  // R4
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_on && hyst_mode && rx_dma_en && !rx_flush && rx_level >= CW'(DEPTH - 2)) |=> rx_req);
  // R5
  rx_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_on && hyst_mode && rx_level == '0) |=> !rx_req);
  // R6
  tx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_on && hyst_mode && tx_dma_en && tx_level == '0) |=> tx_req);
  // R8
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_on && hyst_mode && rx_flush) |=> !rx_req);
endmodule

bind uart_dma_req uart_dma_req_chk #(.CW(CW), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .hyst_mode(hyst_mode),
  .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en), .rx_level(rx_level),
  .tx_level(tx_level), .tx_wr(tx_wr), .rx_flush(rx_flush),
  .rx_req(rx_req), .tx_req(tx_req)
);

// File: tb/uart_dma_req_tb.sv
`timescale 1ns/1ps
module uart_dma_req_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_on = 0, hyst_mode = 0, rx_dma_en = 0, tx_dma_en = 0;
  logic [1:0] trig_sel = 0;
  logic [4:0] rx_level = 0, tx_level = 0;
  logic rx_hold_full = 0, tx_hold_full = 0, rx_timeout = 0, tx_wr = 0;
  logic rx_flush = 0, tx_flush = 0;
  logic rx_req, tx_req;

  int n_chk = 0, n_bad = 0;
  bit m_rx = 0, m_tx = 0;

  always #10 clk = ~clk;

  uart_dma_req dut_i (.*);

  function automatic int trig_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic cmp(input string tag, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    bit hy, nrx, ntx, erx, etx, avail, vac;
    hy    = fifo_on && hyst_mode;
    avail = fifo_on ? (rx_level != 0) : rx_hold_full;
    vac   = fifo_on ? (tx_level == 0) : !tx_hold_full;
    if (rx_flush || rx_level == 0) nrx = 0;
    else if (int'(rx_level) >= trig_of(trig_sel) || rx_timeout) nrx = 1;
    else nrx = m_rx;
    if (tx_flush) ntx = 1;
    else if (tx_level >= 16) ntx = 0;
    else if (tx_level == 0) ntx = 1;
    else ntx = m_tx;
    erx = rx_dma_en && (hy ? nrx : avail);
    etx = tx_dma_en && (hy ? ntx : (vac && !tx_wr));
    m_rx = nrx; m_tx = ntx;
    @(posedge clk); #1;
    cmp(tag, rx_req, erx, "rx_req");
    cmp(tag, tx_req, etx, "tx_req");
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rx_dma_en = 1; tx_dma_en = 1; fifo_on = 1; rx_level = 16;
    repeat (3) @(posedge clk);
    #1;
    cmp("R1", rx_req, 1'b0, "rx_req in reset");
    cmp("R1", tx_req, 1'b0, "tx_req in reset");
    rx_level = 0; rx_dma_en = 0; tx_dma_en = 0; fifo_on = 0;
    rst_n = 1;
    tick("R1");

    rx_dma_en = 1; tx_dma_en = 1;
    // R9: FIFOs off, mode bit must not matter
    for (int i = 0; i < 32; i++) begin
      {hyst_mode, rx_hold_full, tx_hold_full, tx_wr, rx_timeout} = 5'(i);
      rx_level = 5'(i % 17); tx_level = 5'((i * 3) % 17);
      tick("R9");
    end
    hyst_mode = 0; tx_wr = 0; rx_timeout = 0;

    // R2 / R3: immediate policy over every count
    fifo_on = 1;
    for (int w = 0; w < 2; w++)
      for (int c = 0; c <= 16; c++) begin
        rx_level = 5'(c); tx_level = 5'(16 - c); tx_wr = w[0];
        tick("R2/R3");
      end
    tx_wr = 0;

    // R4 / R5: ramp up and down for each trigger code
    hyst_mode = 1;
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      rx_level = 0; tick("R5");
      for (int c = 1; c <= 16; c++) begin rx_level = 5'(c); tick("R4"); end
      for (int c = 15; c >= 0; c--) begin rx_level = 5'(c); tick("R5"); end
    end

    // R4: timeout on empty and on one byte
    trig_sel = 3; rx_level = 0; rx_timeout = 1; tick("R4");
    rx_level = 1; tick("R4");
    rx_timeout = 0; rx_level = 2; tick("R5");
    rx_level = 0; tick("R5");

    // R6: transmit hysteresis
    for (int c = 0; c <= 16; c++) begin tx_level = 5'(c); tick("R6"); end
    for (int c = 15; c >= 0; c--) begin tx_level = 5'(c); tick("R6"); end
    tx_wr = 1; tx_level = 3; tick("R6");
    tx_wr = 0;

    // R8: clears override a full FIFO
    rx_level = 16; tick("R8");
    rx_flush = 1; tick("R8");
    rx_flush = 0; rx_level = 2; trig_sel = 3; tick("R8");
    tx_level = 16; tick("R8");
    tx_level = 8; tick("R8");
    tx_flush = 1; tick("R8");
    tx_flush = 0; tick("R8");
    tx_flush = 1; tx_level = 16; tick("R8");
    tx_flush = 0; tick("R8");

    // R7: random mix with enables toggling
    for (int k = 0; k < 3000; k++) begin
      fifo_on = ($urandom_range(0, 7) != 0);
      hyst_mode = ($urandom_range(0, 3) != 0);
      rx_dma_en = $urandom_range(0, 1); tx_dma_en = $urandom_range(0, 1);
      trig_sel = 2'($urandom_range(0, 3));
      rx_level = 5'($urandom_range(0, 16)); tx_level = 5'($urandom_range(0, 16));
      rx_hold_full = $urandom_range(0, 1); tx_hold_full = $urandom_range(0, 1);
      rx_timeout = ($urandom_range(0, 7) == 0); tx_wr = ($urandom_range(0, 3) == 0);
      rx_flush = ($urandom_range(0, 15) == 0); tx_flush = ($urandom_range(0, 15) == 0);
      tick("R7");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule